// File: doc/BRIEF.md
# Delay-Slot Squash Controller

This block sits in the decode stage of a two-thread pipeline whose branches carry a delay slot. Each cycle it walks one decode group of up to four entries, oldest in slot 0. Only the entries that belong to the thread selected for decode are processed. A control entry flagged as mispredicted starts a squash. The squash boundary is a sequence number, and everything younger than it on that thread is discarded.

There are two kinds of squash. A mispredicted branch that was predicted taken and whose delay slot is conditional (annulled) squashes at once, at its own sequence number. Any other mispredicted branch keeps its delay slot. The block records the branch per thread and fires the squash only after the next entry of that thread has been forwarded, even when that entry arrives in a later group. When a squash fires, the block sends one redirect packet to fetch. It also marks the younger entries of the group as killed and reports how many entries to pop from the head of the thread's decode queue and skid buffer. All outputs are registered and reflect the group presented one cycle earlier.

Top module: `dslot_squash_ctrl`

## Requirements
- R1: After reset, and after any reset pulse, every output is 0 and no deferred squash is pending on either thread.
- R2: A processed entry with control=1, mispredict=1, predicted-taken=1 and conditional-slot=1 fires at once, with done = bound = its own sequence number. No later slot of the group is processed.
- R3: Any other processed entry with control=1 and mispredict=1 sets that thread's pending flag. The squash fires on the next processed entry of the same thread, in this group or a later one, with done = branch sequence and bound = branch sequence + 1. grp_take (bit i = slot i) marks the processed slots, up to and including the slot where a squash fires.
- R4: Pending state is kept per thread, and entries of the other thread neither fire nor clear it.
- R5: On a squash, grp_kill bit i is set when slot i is valid, belongs to the squashing thread, and has a sequence number greater than the bound.
- R6: On a squash, dq_pop and sb_pop count the leading entries (index 0 = head, only the first cnt entries) whose sequence number is greater than the bound, stopping at the first one at or below it. They are 0 when no squash fires.
- R7: rd_valid is high for exactly one cycle per squash, one cycle after the group, with rd_tid, rd_done_seq, rd_bound_seq and rd_target (the branch's target) of the squashing branch.
- R8: rd_taken is 1 when the branch's next-next PC differs from its next PC plus 4.
- R9: rd_unblock is 1 with a squash when dec_blocked was high in the cycle the squash fired.
- R10: pred_err is 1 when any processed entry is predicted taken but not a control entry.
- R11: mispredict=1 on a non-control entry causes no squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_tid | input | TID_W | Thread being decoded this cycle |
| dec_blocked | input | 1 | Decode of dec_tid is blocked or unblocking |
| grp_vld | input | GRP_W | Slot valid |
| grp_tid | input | GRP_W x TID_W | Slot thread |
| grp_pt | input | GRP_W | Slot predicted taken |
| grp_ctrl | input | GRP_W | Slot is a control entry |
| grp_cds | input | GRP_W | Slot branch has a conditional (annulling) delay slot |
| grp_mis | input | GRP_W | Decoder found the prediction wrong |
| grp_seq | input | GRP_W x SEQ_W | Slot sequence number |
| grp_npc | input | GRP_W x PC_W | Next PC |
| grp_nnpc | input | GRP_W x PC_W | PC two ahead |
| grp_tgt | input | GRP_W x PC_W | Branch target |
| dq_seq | input | DQ_D x SEQ_W | Decode queue sequence numbers, index 0 = head |
| dq_cnt | input | clog2(DQ_D+1) | Decode queue occupancy |
| sb_seq | input | SB_D x SEQ_W | Skid buffer sequence numbers, index 0 = head |
| sb_cnt | input | clog2(SB_D+1) | Skid buffer occupancy |
| rd_valid | output | 1 | Redirect valid (mispredict, squash, prediction-wrong) |
| rd_tid | output | TID_W | Redirect thread |
| rd_done_seq | output | SEQ_W | Sequence number of the branch |
| rd_bound_seq | output | SEQ_W | Squash boundary |
| rd_target | output | PC_W | Fetch restart PC |
| rd_taken | output | 1 | Branch resolved taken |
| rd_unblock | output | 1 | Fetch may unblock |
| grp_kill | output | GRP_W | Slots squashed |
| grp_take | output | GRP_W | Slots processed |
| dq_pop | output | clog2(DQ_D+1) | Entries to pop from the decode queue |
| sb_pop | output | clog2(SB_D+1) | Entries to pop from the skid buffer |
| pred_err | output | 1 | Non-control entry predicted taken |

## Verification
A stale or lost per-thread pending flag shows up at the ports. Either a redirect appears on the wrong group, or a redirect is missing one cycle after the delay slot is presented. The bench therefore spreads deferred squashes across groups, thread switches, empty groups and a reset. A wrong boundary register moves rd_bound_seq by one and changes the kill mask and pop counts in the same output cycle. The queue images place entries at or below the bound behind larger ones, so that an early stop or an overrun changes the count at once.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
    localparam int unsigned SEQ_W = 16;
    localparam int unsigned PC_W  = 32;
    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;
endpackage

// File: rtl/dslot_flush.sv
module dslot_flush
    import dslot_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  seq_t [DEPTH-1:0] seq_i,
    input  logic [CW-1:0]    cnt_i,
    input  seq_t             bound_i,
    output logic [CW-1:0]    pop_o
);
    logic run;

    // count head entries younger than the bound; stop at the first survivor
    always_comb begin
        pop_o = '0;
        run   = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (run && (CW'(i) < cnt_i) && (seq_i[i] > bound_i)) begin
                pop_o = pop_o + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dslot_scan.sv
module dslot_scan
    import dslot_pkg::*;
#(
    parameter int unsigned GRP_W      = 4,
    parameter int unsigned TID_W      = 1,
    parameter int unsigned INST_BYTES = 4
) (
    input  logic [TID_W-1:0]            dec_tid,
    input  logic [GRP_W-1:0]            vld_i,
    input  logic [GRP_W-1:0][TID_W-1:0] tid_i,
    input  logic [GRP_W-1:0]            pt_i,
    input  logic [GRP_W-1:0]            ctrl_i,
    input  logic [GRP_W-1:0]            cds_i,
    input  logic [GRP_W-1:0]            mis_i,
    input  seq_t [GRP_W-1:0]            seq_i,
    input  pc_t  [GRP_W-1:0]            npc_i,
    input  pc_t  [GRP_W-1:0]            nnpc_i,
    input  pc_t  [GRP_W-1:0]            tgt_i,
    input  logic                        pend_i,
    input  seq_t                        pseq_i,
    input  pc_t                         ptgt_i,
    input  logic                        ptk_i,
    output logic                        fire_o,
    output seq_t                        done_o,
    output seq_t                        bound_o,
    output pc_t                         tgt_o,
    output logic                        tk_o,
    output logic [GRP_W-1:0]            take_o,
    output logic                        err_o,
    output logic                        pend_o,
    output seq_t                        pseq_o,
    output pc_t                         ptgt_o,
    output logic                        ptk_o
);
    logic [GRP_W-1:0] taken_w;
    logic             stop;

    for (genvar g = 0; g < GRP_W; g++) begin : g_taken
        assign taken_w[g] = nnpc_i[g] != (npc_i[g] + PC_W'(INST_BYTES));
    end

    always_comb begin
        pend_o  = pend_i;
        pseq_o  = pseq_i;
        ptgt_o  = ptgt_i;
        ptk_o   = ptk_i;
        fire_o  = 1'b0;
        done_o  = '0;
        bound_o = '0;
        tgt_o   = '0;
        tk_o    = 1'b0;
        take_o  = '0;
        err_o   = 1'b0;
        stop    = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            if (!stop && vld_i[i] && (tid_i[i] == dec_tid)) begin
                take_o[i] = 1'b1;
                if (pt_i[i] && !ctrl_i[i]) err_o = 1'b1;
                if (pend_o) begin
                    // delay slot forwarded: deferred squash fires now
                    fire_o  = 1'b1;
                    stop    = 1'b1;
                    pend_o  = 1'b0;
                    done_o  = pseq_o;
                    bound_o = pseq_o + 1'b1;
                    tgt_o   = ptgt_o;
                    tk_o    = ptk_o;
                end else if (ctrl_i[i] && mis_i[i]) begin
                    if (pt_i[i] && cds_i[i]) begin
                        fire_o  = 1'b1;
                        stop    = 1'b1;
                        done_o  = seq_i[i];
                        bound_o = seq_i[i];
                        tgt_o   = tgt_i[i];
                        tk_o    = taken_w[i];
                    end else begin
                        pend_o = 1'b1;
                        pseq_o = seq_i[i];
                        ptgt_o = tgt_i[i];
                        ptk_o  = taken_w[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dslot_squash_ctrl.sv
module dslot_squash_ctrl
    import dslot_pkg::*;
#(
    parameter int unsigned GRP_W      = 4,
    parameter int unsigned NTHR       = 2,
    parameter int unsigned DQ_D       = 4,
    parameter int unsigned SB_D       = 4,
    parameter int unsigned INST_BYTES = 4,
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int unsigned DQ_CW = $clog2(DQ_D + 1),
    localparam int unsigned SB_CW = $clog2(SB_D + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TID_W-1:0]            dec_tid,
    input  logic                        dec_blocked,
    input  logic [GRP_W-1:0]            grp_vld,
    input  logic [GRP_W-1:0][TID_W-1:0] grp_tid,
    input  logic [GRP_W-1:0]            grp_pt,
    input  logic [GRP_W-1:0]            grp_ctrl,
    input  logic [GRP_W-1:0]            grp_cds,
    input  logic [GRP_W-1:0]            grp_mis,
    input  logic [GRP_W-1:0][SEQ_W-1:0] grp_seq,
    input  logic [GRP_W-1:0][PC_W-1:0]  grp_npc,
    input  logic [GRP_W-1:0][PC_W-1:0]  grp_nnpc,
    input  logic [GRP_W-1:0][PC_W-1:0]  grp_tgt,
    input  logic [DQ_D-1:0][SEQ_W-1:0]  dq_seq,
    input  logic [DQ_CW-1:0]            dq_cnt,
    input  logic [SB_D-1:0][SEQ_W-1:0]  sb_seq,
    input  logic [SB_CW-1:0]            sb_cnt,
    output logic                        rd_valid,
    output logic [TID_W-1:0]            rd_tid,
    output logic [SEQ_W-1:0]            rd_done_seq,
    output logic [SEQ_W-1:0]            rd_bound_seq,
    output logic [PC_W-1:0]             rd_target,
    output logic                        rd_taken,
    output logic                        rd_unblock,
    output logic [GRP_W-1:0]            grp_kill,
    output logic [GRP_W-1:0]            grp_take,
    output logic [DQ_CW-1:0]            dq_pop,
    output logic [SB_CW-1:0]            sb_pop,
    output logic                        pred_err
);
    typedef struct packed {
        logic [NTHR-1:0]   pend;
        seq_t [NTHR-1:0]   bseq;
        pc_t  [NTHR-1:0]   btgt;
        logic [NTHR-1:0]   btk;
        logic              rv;
        logic [TID_W-1:0]  tid;
        seq_t              done;
        seq_t              bnd;
        pc_t               tgt;
        logic              tk;
        logic              ub;
        logic [GRP_W-1:0]  kill;
        logic [GRP_W-1:0]  take;
        logic [DQ_CW-1:0]  dqp;
        logic [SB_CW-1:0]  sbp;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic             sc_fire, sc_tk, sc_err, sc_pend, sc_ptk;
    seq_t             sc_done, sc_bound, sc_pseq;
    pc_t              sc_tgt, sc_ptgt;
    logic [GRP_W-1:0] sc_take;
    logic [DQ_CW-1:0] dq_n;
    logic [SB_CW-1:0] sb_n;

    dslot_scan #(.GRP_W(GRP_W), .TID_W(TID_W), .INST_BYTES(INST_BYTES)) u_scan (
        .dec_tid (dec_tid),
        .vld_i   (grp_vld),
        .tid_i   (grp_tid),
        .pt_i    (grp_pt),
        .ctrl_i  (grp_ctrl),
        .cds_i   (grp_cds),
        .mis_i   (grp_mis),
        .seq_i   (grp_seq),
        .npc_i   (grp_npc),
        .nnpc_i  (grp_nnpc),
        .tgt_i   (grp_tgt),
        .pend_i  (st_q.pend[dec_tid]),
        .pseq_i  (st_q.bseq[dec_tid]),
        .ptgt_i  (st_q.btgt[dec_tid]),
        .ptk_i   (st_q.btk[dec_tid]),
        .fire_o  (sc_fire),
        .done_o  (sc_done),
        .bound_o (sc_bound),
        .tgt_o   (sc_tgt),
        .tk_o    (sc_tk),
        .take_o  (sc_take),
        .err_o   (sc_err),
        .pend_o  (sc_pend),
        .pseq_o  (sc_pseq),
        .ptgt_o  (sc_ptgt),
        .ptk_o   (sc_ptk)
    );

    dslot_flush #(.DEPTH(DQ_D)) u_dq_flush (
        .seq_i   (dq_seq),
        .cnt_i   (dq_cnt),
        .bound_i (sc_bound),
        .pop_o   (dq_n)
    );

    dslot_flush #(.DEPTH(SB_D)) u_sb_flush (
        .seq_i   (sb_seq),
        .cnt_i   (sb_cnt),
        .bound_i (sc_bound),
        .pop_o   (sb_n)
    );

    always_comb begin
        st_d                = st_q;
        st_d.pend[dec_tid]  = sc_pend;
        st_d.bseq[dec_tid]  = sc_pseq;
        st_d.btgt[dec_tid]  = sc_ptgt;
        st_d.btk[dec_tid]   = sc_ptk;
        st_d.rv             = sc_fire;
        st_d.tid            = sc_fire ? dec_tid : '0;
        st_d.done           = sc_done;
        st_d.bnd            = sc_bound;
        st_d.tgt            = sc_tgt;
        st_d.tk             = sc_tk;
        st_d.ub             = sc_fire & dec_blocked;
        for (int i = 0; i < GRP_W; i++) begin
            st_d.kill[i] = sc_fire && grp_vld[i] && (grp_tid[i] == dec_tid)
                           && (grp_seq[i] > sc_bound);
        end
        st_d.take           = sc_take;
        st_d.dqp            = sc_fire ? dq_n : '0;
        st_d.sbp            = sc_fire ? sb_n : '0;
        st_d.err            = sc_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid     = st_q.rv;
    assign rd_tid       = st_q.tid;
    assign rd_done_seq  = st_q.done;
    assign rd_bound_seq = st_q.bnd;
    assign rd_target    = st_q.tgt;
    assign rd_taken     = st_q.tk;
    assign rd_unblock   = st_q.ub;
    assign grp_kill     = st_q.kill;
    assign grp_take     = st_q.take;
    assign dq_pop       = st_q.dqp;
    assign sb_pop       = st_q.sbp;
    assign pred_err     = st_q.err;

    // a fired squash leaves its thread with nothing pending
    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !st_q.pend[rd_tid]);

    // boundary sits at the branch or exactly one past it
    assert_bound_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_bound_seq == rd_done_seq) ||
                      (rd_bound_seq == rd_done_seq + 1'b1)));

    // kills and pops never appear without a redirect
    assert_kill_with_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grp_kill) || (|dq_pop) || (|sb_pop)) |-> rd_valid);

    // unblock only accompanies a squash taken while blocked
    assert_unblock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unblock |-> (rd_valid && $past(dec_blocked)));

    // pop counts never exceed the occupancy seen with the group
    assert_pop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((dq_pop <= $past(dq_cnt)) && (sb_pop <= $past(sb_cnt))));
endmodule

// File: tb/tb_dslot_squash_ctrl.sv
module tb_dslot_squash_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int QD = 4;
    localparam int NV = 12;
    localparam logic [22:0] Z = '0;

    typedef struct packed {
        logic [91:0] ent;
        logic        tid;
        logic        blk;
        logic [2:0]  dqc;
        logic [63:0] dq;
        logic [2:0]  sbc;
        logic [63:0] sb;
        logic        ev;
        logic [15:0] edone;
        logic [15:0] ebnd;
        logic        etk;
        logic        eub;
        logic [3:0]  ekill;
        logic [3:0]  etake;
        logic [2:0]  edq;
        logic [2:0]  esb;
        logic        eerr;
    } vec_t;

    // entry: {valid, tid, pred_taken, ctrl, cond_slot, mispredict, taken, seq}
    function automatic logic [22:0] en(int tid, int pt, int c, int cds, int mis, int tk, int seq);
        return {1'b1, 1'(tid), 1'(pt), 1'(c), 1'(cds), 1'(mis), 1'(tk), 16'(seq)};
    endfunction

    // queue image, first argument is the head
    function automatic logic [63:0] q4(int a, int b, int c, int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    function automatic vec_t mk(logic [22:0] e0, logic [22:0] e1, logic [22:0] e2, logic [22:0] e3,
                                int tid, int blk, int dqc, logic [63:0] dq, int sbc, logic [63:0] sb,
                                int ev, int done, int bnd, int tk, int ub,
                                int kill, int take, int edq, int esb, int err);
        vec_t v;
        v.ent = {e3, e2, e1, e0};
        v.tid = 1'(tid);   v.blk = 1'(blk);
        v.dqc = 3'(dqc);   v.dq = dq;
        v.sbc = 3'(sbc);   v.sb = sb;
        v.ev = 1'(ev);     v.edone = 16'(done); v.ebnd = 16'(bnd);
        v.etk = 1'(tk);    v.eub = 1'(ub);
        v.ekill = 4'(kill); v.etake = 4'(take);
        v.edq = 3'(edq);   v.esb = 3'(esb);  v.eerr = 1'(err);
        return v;
    endfunction

    localparam vec_t VEC [NV] = '{
        // 0 idle
        mk(Z, Z, Z, Z, 0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        // 1 plain group, all taken through
        mk(en(0,0,0,0,0,0,10), en(0,0,0,0,0,0,11), en(0,0,0,0,0,0,12), en(0,0,0,0,0,0,13),
           0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'h0, 4'hF, 0, 0, 0),
        // 2 R2 immediate squash at slot 1
        mk(en(0,0,0,0,0,0,20), en(0,1,1,1,1,1,21), en(0,0,0,0,0,0,22), en(0,0,0,0,0,0,23),
           0, 0, 2, q4(30,31,0,0), 0, '0, 1, 21, 21, 1, 0, 4'b1100, 4'b0011, 2, 0, 0),
        // 3 R3 deferred inside group, R6 queue stop, R9 blocked
        mk(en(0,0,1,0,1,1,40), en(0,0,0,0,0,0,41), en(0,0,0,0,0,0,42), en(0,0,0,0,0,0,43),
           0, 1, 3, q4(45,41,46,0), 2, q4(41,50,0,0), 1, 40, 41, 1, 1, 4'b1100, 4'b0011, 1, 0, 0),
        // 4 R3 deferred as last entry of the thread, not taken
        mk(en(0,0,0,0,0,0,58), en(0,0,0,0,0,0,59), en(0,1,1,0,1,0,60), Z,
           0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'b0000, 4'b0111, 0, 0, 0),
        // 5 delay slot in next group fires; thread-1 slot spared
        mk(en(0,0,0,0,0,0,61), en(0,0,0,0,0,0,62), en(1,0,0,0,0,0,63), en(0,0,0,0,0,0,64),
           0, 0, 1, q4(70,0,0,0), 1, q4(61,0,0,0), 1, 60, 61, 0, 0, 4'b1010, 4'b0001, 1, 0, 0),
        // 6 deferred branch on thread 0
        mk(en(0,0,1,0,1,1,80), Z, Z, Z,
           0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'b0000, 4'b0001, 0, 0, 0),
        // 7 R4 thread 1 decodes, thread 0 pending untouched
        mk(en(1,0,0,0,0,0,90), en(1,0,0,0,0,0,91), Z, Z,
           1, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'b0000, 4'b0011, 0, 0, 0),
        // 8 R4 thread 0 delay slot fires its own squash
        mk(en(0,0,0,0,0,0,81), Z, Z, Z,
           0, 0, 0, '0, 0, '0, 1, 80, 81, 1, 0, 4'b0000, 4'b0001, 0, 0, 0),
        // 9 R10 predicted taken on a non-control entry
        mk(en(0,1,0,0,0,0,100), Z, Z, Z,
           0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'b0000, 4'b0001, 0, 0, 1),
        // 10 thread 1 immediate squash while blocked, skid buffer stop
        mk(en(1,1,1,1,1,1,120), en(1,0,0,0,0,0,121), en(0,0,0,0,0,0,122), en(1,0,0,0,0,0,119),
           1, 1, 0, '0, 3, q4(130,125,120,0), 1, 120, 120, 1, 1, 4'b0010, 4'b0001, 0, 2, 0),
        // 11 R11 mispredict on non-control is ignored
        mk(en(0,0,0,0,1,0,140), en(0,0,0,0,0,0,141), Z, Z,
           0, 0, 0, '0, 0, '0, 0, 0, 0, 0, 0, 4'b0000, 4'b0011, 0, 0, 0)
    };

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [0:0]            dec_tid;
    logic                  dec_blocked;
    logic [W-1:0]          grp_vld, grp_pt, grp_ctrl, grp_cds, grp_mis;
    logic [W-1:0][0:0]     grp_tid;
    logic [W-1:0][15:0]    grp_seq;
    logic [W-1:0][31:0]    grp_npc, grp_nnpc, grp_tgt;
    logic [QD-1:0][15:0]   dq_seq, sb_seq;
    logic [2:0]            dq_cnt, sb_cnt;
    logic                  rd_valid, rd_taken, rd_unblock, pred_err;
    logic [0:0]            rd_tid;
    logic [15:0]           rd_done_seq, rd_bound_seq;
    logic [31:0]           rd_target;
    logic [W-1:0]          grp_kill, grp_take;
    logic [2:0]            dq_pop, sb_pop;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    dslot_squash_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dec_tid(dec_tid), .dec_blocked(dec_blocked),
        .grp_vld(grp_vld), .grp_tid(grp_tid), .grp_pt(grp_pt), .grp_ctrl(grp_ctrl),
        .grp_cds(grp_cds), .grp_mis(grp_mis), .grp_seq(grp_seq), .grp_npc(grp_npc),
        .grp_nnpc(grp_nnpc), .grp_tgt(grp_tgt), .dq_seq(dq_seq), .dq_cnt(dq_cnt),
        .sb_seq(sb_seq), .sb_cnt(sb_cnt), .rd_valid(rd_valid), .rd_tid(rd_tid),
        .rd_done_seq(rd_done_seq), .rd_bound_seq(rd_bound_seq), .rd_target(rd_target),
        .rd_taken(rd_taken), .rd_unblock(rd_unblock), .grp_kill(grp_kill),
        .grp_take(grp_take), .dq_pop(dq_pop), .sb_pop(sb_pop), .pred_err(pred_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        for (int i = 0; i < W; i++) begin
            logic [22:0] e;
            e = v.ent[i*23 +: 23];
            grp_vld[i]  = e[22];
            grp_tid[i]  = e[21];
            grp_pt[i]   = e[20];
            grp_ctrl[i] = e[19];
            grp_cds[i]  = e[18];
            grp_mis[i]  = e[17];
            grp_seq[i]  = e[15:0];
            grp_npc[i]  = 32'h100;
            grp_nnpc[i] = e[16] ? 32'h200 : 32'h104;
            grp_tgt[i]  = 32'hA000_0000 | {16'h0, e[15:0]};
        end
        for (int i = 0; i < QD; i++) begin
            dq_seq[i] = v.dq[i*16 +: 16];
            sb_seq[i] = v.sb[i*16 +: 16];
        end
        dq_cnt      = v.dqc;
        sb_cnt      = v.sbc;
        dec_tid     = v.tid;
        dec_blocked = v.blk;
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic run_vec(input vec_t v);
        drive(v);
        @(negedge clk);
        chk("R7 rd_valid", 32'(rd_valid), 32'(v.ev));
        if (v.ev) begin
            chk("R7 rd_done_seq", 32'(rd_done_seq), 32'(v.edone));
            chk("R2/R3 rd_bound_seq", 32'(rd_bound_seq), 32'(v.ebnd));
            chk("R7 rd_target", rd_target, 32'hA000_0000 | 32'(v.edone));
            chk("R7 rd_tid", 32'(rd_tid), 32'(v.tid));
            chk("R8 rd_taken", 32'(rd_taken), 32'(v.etk));
            chk("R9 rd_unblock", 32'(rd_unblock), 32'(v.eub));
        end
        chk("R5 grp_kill", 32'(grp_kill), 32'(v.ekill));
        chk("R3 grp_take", 32'(grp_take), 32'(v.etake));
        chk("R6 dq_pop", 32'(dq_pop), 32'(v.edq));
        chk("R6 sb_pop", 32'(sb_pop), 32'(v.esb));
        chk("R10 pred_err", 32'(pred_err), 32'(v.eerr));
    endtask

    initial begin
        rst_n = 1'b0;
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 grp_take", 32'(grp_take), 0);
        chk("R1 grp_kill", 32'(grp_kill), 0);
        chk("R1 pops", 32'({dq_pop, sb_pop}), 0);
        chk("R1 pred_err", 32'(pred_err), 0);
        chk("R1 rd_fields", 32'({rd_unblock, rd_taken, rd_tid}) | rd_target | 32'(rd_done_seq), 0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R7 redirect lasts one cycle
        run_vec(mk(en(0,1,1,1,1,1,220), Z, Z, Z, 0, 0, 0, '0, 0, '0,
                   1, 220, 220, 1, 0, 0, 4'b0001, 0, 0, 0));
        run_vec(VEC[0]);

        // R3 pending survives a group with nothing for the thread
        run_vec(mk(en(0,0,1,0,1,1,210), Z, Z, Z, 0, 0, 0, '0, 0, '0,
                   0, 0, 0, 0, 0, 0, 4'b0001, 0, 0, 0));
        run_vec(VEC[0]);
        run_vec(mk(en(0,0,0,0,0,0,211), Z, Z, Z, 0, 0, 0, '0, 0, '0,
                   1, 210, 211, 1, 0, 0, 4'b0001, 0, 0, 0));

        // R1 reset drops a pending deferred squash
        run_vec(mk(Z, Z, Z, en(0,0,1,0,1,1,200), 0, 0, 0, '0, 0, '0,
                   0, 0, 0, 0, 0, 0, 4'b1000, 0, 0, 0));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_vec(mk(en(0,0,0,0,0,0,201), Z, Z, Z, 0, 0, 0, '0, 0, '0,
                   0, 0, 0, 0, 0, 0, 4'b0001, 0, 0, 0));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule